// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounce

This block scans a 5-row by 3-column key matrix and turns each press into a 4-bit key code. It drives the rows with a single low bit that walks from row to row, and it watches three active-low column lines through a two-flop synchronizer. When a column reads low at the end of a row's dwell time, the scan freezes on that row. The block records the column and starts a loadable down-counter that sets the debounce interval.

When the count runs out, the block looks at the recorded column again. If the key is still down and the matrix position holds a key, the block emits the code from a position table together with a one-cycle valid strobe. It then waits until every column is released before it scans again. A column that has gone high by then counts as a bounce: the block drops the press and scanning goes on. The debounce preset and the dwell time per row are parameters. Silicon uses a preset in the range of milliseconds. A bench uses a short one.

Top module: `keypad_scanner`

## Requirements
- R1: While reset is asserted and right after it, `row_no` is 5'b01111, `key_valid_o` is 0 and `key_code_o` is 0.
- R2: With no key pressed, `row_no` always has exactly one zero bit. Every SCAN_DIV cycles it rotates right by one, so the sequence is 01111, 10111, 11011, 11101, 11110, and then it repeats. Matrix row k is the row whose zero sits at bit 4-k.
- R3: A column that reads low at the end of a row's dwell freezes `row_no` for the whole debounce interval and for as long as the key stays held.
- R4: The debounce counter holds the value DBNC_PRESET whenever the block is not debouncing. No strobe comes earlier than DBNC_PRESET+1 cycles after the key goes down.
- R5: If the recorded column still reads low when the count reaches zero, `key_valid_o` goes high for exactly one cycle, carrying the code of the key.
- R6: Key codes by position (row, column): rows 0 to 2 give the digits 1 to 9 as 3*row+col+1. Row 3 gives 4'b1010 (A) at col 0, 0 at col 1 and 4'b1011 (B) at col 2. Row 4 col 0 gives 4'b1111 (O).
- R7: If the recorded column reads high when the count ends, the block emits no strobe and scanning resumes.
- R8: After a strobe, a key that stays held gives no further strobe. The rows stay frozen until all three columns read high, and after that scanning resumes.
- R9: The positions row 4 col 1 and row 4 col 2 hold no key. A press there never raises `key_valid_o`, and codes 12 to 14 never appear with a strobe.
- R10: If two or more columns read low on the same row, the column with the lowest index is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| col_ni | input | 3 | Column sense lines, active low (bit c = column c) |
| row_no | output | 5 | Row drive, one-cold |
| key_valid_o | output | 1 | One-cycle strobe for an accepted key |
| key_code_o | output | 4 | Code of the most recent accepted key |

## Verification
The bench presses every populated key and checks the code and the one-cycle strobe width. It also checks that the strobe never comes too early: a design that skips the debounce wait, or that misattributes the row because of the synchronizer lag, would report the wrong code or strobe too soon. A held key must give exactly one strobe and keep the rows frozen, so a design that re-arms before release repeats the key. A press released part way through the debounce must give nothing. The bench also presses the unpopulated positions, where a design with a missing table guard would emit codes. Two columns pressed together must resolve to the lower column, and the bench checks the scan order against a right rotation with a fixed dwell.

// File: rtl/kp_pkg.sv
package kp_pkg;
  typedef enum logic [1:0] {ST_SCAN, ST_DBNC, ST_HOLD} kp_state_e;

  // matrix position -> key code; miss for unpopulated positions
  function automatic logic [4:0] pos_to_code(input int unsigned pos);
    logic [4:0] r;
    if (pos < 9)        r = {1'b1, 4'(pos + 1)};
    else if (pos == 9)  r = 5'b1_1010;
    else if (pos == 10) r = 5'b1_0000;
    else if (pos == 11) r = 5'b1_1011;
    else if (pos == 12) r = 5'b1_1111;
    else                r = 5'b0_0000;
    return r;
  endfunction
endpackage

// File: rtl/kp_row_scanner.sv
module kp_row_scanner #(
  parameter int ROWS = 5,
  localparam int RW = $clog2(ROWS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  output logic [ROWS-1:0] row_no,
  output logic [RW-1:0]   row_idx_o
);
  logic [ROWS-1:0] row_q;
  logic [RW-1:0]   idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= {1'b0, {(ROWS-1){1'b1}}};
      idx_q <= '0;
    end else if (adv_i) begin
      row_q <= {row_q[0], row_q[ROWS-1:1]};
      idx_q <= (idx_q == RW'(ROWS-1)) ? '0 : idx_q + 1'b1;
    end
  end

  assign row_no    = row_q;
  assign row_idx_o = idx_q;
endmodule

// File: rtl/kp_dbnc_timer.sv
module kp_dbnc_timer #(
  parameter int PRESET = 10000,
  localparam int CW = $clog2(PRESET + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          preset_i,
  output logic          done_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= CW'(PRESET);
    else if (preset_i)       cnt_q <= CW'(PRESET);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = !preset_i && (cnt_q == '0);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/kp_code_lut.sv
module kp_code_lut #(
  parameter int COLS = 3,
  parameter int RW   = 3,
  parameter int CIW  = 2
) (
  input  logic [RW-1:0]  row_idx_i,
  input  logic [CIW-1:0] col_idx_i,
  output logic [3:0]     code_o,
  output logic           hit_o
);
  logic [4:0] ent;

  always_comb begin
    ent    = kp_pkg::pos_to_code(int'(row_idx_i) * COLS + int'(col_idx_i));
    hit_o  = ent[4];
    code_o = ent[3:0];
  end
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
  parameter int ROWS        = 5,
  parameter int COLS        = 3,
  parameter int SCAN_DIV    = 64,
  parameter int DBNC_PRESET = 10000,
  localparam int RW  = $clog2(ROWS),
  localparam int CIW = $clog2(COLS),
  localparam int DW  = $clog2(SCAN_DIV),
  localparam int CW  = $clog2(DBNC_PRESET + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [COLS-1:0] col_ni,
  output logic [ROWS-1:0] row_no,
  output logic            key_valid_o,
  output logic [3:0]      key_code_o
);
  import kp_pkg::*;

  // dwell must cover the two-flop column lag
  initial if (SCAN_DIV < 3) $error("SCAN_DIV must be at least 3");

  kp_state_e       state_q;
  logic [COLS-1:0] col_m, col_s;
  logic [DW-1:0]   div_q;
  logic [CIW-1:0]  col_q, low_idx;
  logic [RW-1:0]   row_idx;
  logic            any_low, eval, adv, dbnc_done, lut_hit;
  logic [3:0]      lut_code;
  logic [CW-1:0]   dbnc_cnt;
  logic            valid_q;
  logic [3:0]      code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_m <= '1;
      col_s <= '1;
    end else begin
      col_m <= col_ni;
      col_s <= col_m;
    end
  end

  assign any_low = ~&col_s;

  always_comb begin
    low_idx = '0;
    for (int c = COLS - 1; c >= 0; c--)
      if (!col_s[c]) low_idx = CIW'(c);
  end

  assign eval = (state_q == ST_SCAN) && (div_q == DW'(SCAN_DIV - 1));
  assign adv  = eval && !any_low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (state_q != ST_SCAN) div_q <= '0;
    else if (eval)              div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end

  kp_row_scanner #(.ROWS(ROWS)) u_rows (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv),
    .row_no    (row_no),
    .row_idx_o (row_idx)
  );

  kp_dbnc_timer #(.PRESET(DBNC_PRESET)) u_dbnc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .preset_i (state_q != ST_DBNC),
    .done_o   (dbnc_done),
    .cnt_o    (dbnc_cnt)
  );

  kp_code_lut #(.COLS(COLS), .RW(RW), .CIW(CIW)) u_lut (
    .row_idx_i (row_idx),
    .col_idx_i (col_q),
    .code_o    (lut_code),
    .hit_o     (lut_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SCAN;
      col_q   <= '0;
      valid_q <= 1'b0;
      code_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_SCAN: if (eval && any_low) begin
          col_q   <= low_idx;
          state_q <= ST_DBNC;
        end
        ST_DBNC: if (dbnc_done) begin
          if (!col_s[col_q]) begin
            state_q <= ST_HOLD;
            if (lut_hit) begin
              valid_q <= 1'b1;
              code_q  <= lut_code;
            end
          end else begin
            state_q <= ST_SCAN;  // bounce
          end
        end
        ST_HOLD: if (&col_s) state_q <= ST_SCAN;
        default: state_q <= ST_SCAN;
      endcase
    end
  end

  assign key_valid_o = valid_q;
  assign key_code_o  = code_q;
endmodule

// File: rtl/kp_checker.sv
module kp_checker #(
  parameter int ROWS        = 5,
  parameter int COLS        = 3,
  parameter int DBNC_PRESET = 10000,
  localparam int CW = $clog2(DBNC_PRESET + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ROWS-1:0]   row_no,
  input logic              key_valid_o,
  input logic [3:0]        key_code_o,
  input kp_pkg::kp_state_e state_i,
  input logic [CW-1:0]     cnt_i,
  input logic [COLS-1:0]   col_s_i
);
  import kp_pkg::*;

  AST_ROW_ONE_COLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~row_no) == 1);  // R2
  AST_ROW_ROTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_no != $past(row_no)) |-> (row_no == {$past(row_no[0]), $past(row_no[ROWS-1:1])}));  // R2
  AST_ROW_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_SCAN) |=> $stable(row_no));  // R3
  AST_PRESET_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_DBNC) |=> (cnt_i == CW'(DBNC_PRESET)));  // R4
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |=> !key_valid_o);  // R5
  AST_VALID_AFTER_DBNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |-> ($past(state_i) == ST_DBNC) && (state_i == ST_HOLD));  // R5
  AST_HOLD_UNTIL_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_HOLD && !(&col_s_i)) |=> (state_i == ST_HOLD));  // R8
  AST_NO_HOLE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |-> !(key_code_o inside {4'd12, 4'd13, 4'd14}));  // R9
endmodule

bind keypad_scanner kp_checker #(
  .ROWS(ROWS), .COLS(COLS), .DBNC_PRESET(DBNC_PRESET)
) u_kp_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .row_no      (row_no),
  .key_valid_o (key_valid_o),
  .key_code_o  (key_code_o),
  .state_i     (state_q),
  .cnt_i       (dbnc_cnt),
  .col_s_i     (col_s)
);

// File: tb/tb_keypad_scanner.sv
module tb_keypad_scanner;
  localparam int ROWS = 5;
  localparam int COLS = 3;
  localparam int SDIV = 4;
  localparam int PRE  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [COLS-1:0] col_n;
  logic [ROWS-1:0] row_n;
  logic key_valid;
  logic [3:0] key_code;
  logic pressed [ROWS][COLS];

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  keypad_scanner #(.ROWS(ROWS), .COLS(COLS), .SCAN_DIV(SDIV), .DBNC_PRESET(PRE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .col_ni(col_n),
    .row_no(row_n), .key_valid_o(key_valid), .key_code_o(key_code)
  );

  // matrix model: column low when a pressed key sits on the driven row
  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      col_n[c] = 1'b1;
      for (int r = 0; r < ROWS; r++)
        if (pressed[r][c] && !row_n[ROWS-1-r]) col_n[c] = 1'b0;
    end
  end

  // {row[2:0], col[1:0], code[3:0]}
  localparam logic [8:0] KEYS [13] = '{
    {3'd0, 2'd0, 4'd1},  {3'd0, 2'd1, 4'd2},  {3'd0, 2'd2, 4'd3},
    {3'd1, 2'd0, 4'd4},  {3'd1, 2'd1, 4'd5},  {3'd1, 2'd2, 4'd6},
    {3'd2, 2'd0, 4'd7},  {3'd2, 2'd1, 4'd8},  {3'd2, 2'd2, 4'd9},
    {3'd3, 2'd0, 4'hA},  {3'd3, 2'd1, 4'd0},  {3'd3, 2'd2, 4'hB},
    {3'd4, 2'd0, 4'hF}
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic release_all();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) pressed[r][c] = 1'b0;
  endtask

  // waits up to maxc cycles for a strobe; checks its width
  task automatic wait_valid(input int maxc, output bit got, output int lat, output logic [3:0] code);
    got = 0; lat = 0; code = '0;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (key_valid) begin
        got = 1; lat = i; code = key_code;
        @(negedge clk);
        chk(!key_valid, "R5", "strobe width", int'(key_valid), 0);
        break;
      end
    end
  endtask

  task automatic check_scan_resumes(input string req);
    logic [ROWS-1:0] p;
    bit moved;
    repeat (8) @(negedge clk);
    p = row_n; moved = 0;
    for (int i = 0; i < 3 * SDIV; i++) begin
      @(negedge clk);
      if (row_n != p) moved = 1;
    end
    chk(moved, req, "scan resumes", int'(moved), 1);
  endtask

  initial begin
    int w;
    for (w = 0; w < 150000; w++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", w, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit got;
    int lat;
    logic [3:0] code;
    logic [ROWS-1:0] prev;
    int dwell, changes;
    bit held_extra, frozen;

    release_all();
    repeat (3) @(negedge clk);
    chk(row_n == 5'b01111, "R1", "rows in reset", int'(row_n), 5'b01111);
    chk(!key_valid && key_code == 0, "R1", "valid/code in reset", int'({key_valid, key_code}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(row_n == 5'b01111, "R1", "rows after reset", int'(row_n), 5'b01111);

    // R2: rotation right, fixed dwell
    prev = row_n; dwell = 1; changes = 0;
    for (int i = 0; i < 12 * SDIV; i++) begin
      @(negedge clk);
      if (row_n != prev) begin
        chk(row_n == {prev[0], prev[ROWS-1:1]}, "R2", "rotate", int'(row_n), int'({prev[0], prev[ROWS-1:1]}));
        if (changes > 0) chk(dwell == SDIV, "R2", "dwell", dwell, SDIV);
        changes++; dwell = 1; prev = row_n;
      end else dwell++;
    end
    chk(changes >= 10, "R2", "row changes", changes, 11);

    // R5/R6: every populated key through the vector table
    foreach (KEYS[k]) begin
      pressed[KEYS[k][8:6]][KEYS[k][5:4]] = 1'b1;
      wait_valid(PRE + ROWS * SDIV + 40, got, lat, code);
      chk(got, "R5", $sformatf("strobe key %0d", k), int'(got), 1);
      chk(code == KEYS[k][3:0], "R6", $sformatf("code key %0d", k), int'(code), int'(KEYS[k][3:0]));
      chk(lat >= PRE + 1, "R4", "debounce latency", lat, PRE + 1);
      // R3/R8: held key, frozen rows, no repeat
      prev = row_n; held_extra = 0; frozen = 1;
      for (int i = 0; i < 3 * PRE; i++) begin
        @(negedge clk);
        if (key_valid) held_extra = 1;
        if (row_n != prev) frozen = 0;
      end
      chk(!held_extra, "R8", "no repeat while held", int'(held_extra), 0);
      chk(frozen, "R3", "rows frozen while held", int'(frozen), 1);
      release_all();
      check_scan_resumes("R8");
    end

    // R9: unpopulated positions
    for (int c = 1; c < COLS; c++) begin
      pressed[4][c] = 1'b1;
      wait_valid(PRE + ROWS * SDIV + 40, got, lat, code);
      chk(!got, "R9", $sformatf("no strobe row4 col%0d", c), int'(got), 0);
      release_all();
      check_scan_resumes("R9");
    end

    // R10: two columns on one row -> lower column
    repeat (20) @(negedge clk);
    pressed[1][1] = 1'b1; pressed[1][2] = 1'b1;
    wait_valid(PRE + ROWS * SDIV + 40, got, lat, code);
    chk(got && code == 4'd5, "R10", "lowest column wins", int'(code), 5);
    release_all();
    check_scan_resumes("R10");

    // R7: bounce released mid-debounce
    repeat (20) @(negedge clk);
    pressed[2][1] = 1'b1;
    repeat (30) @(negedge clk);
    release_all();
    wait_valid(4 * PRE, got, lat, code);
    chk(!got, "R7", "bounce gives no strobe", int'(got), 0);
    check_scan_resumes("R7");

    // R1: reset mid-debounce
    pressed[0][0] = 1'b1;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(row_n == 5'b01111, "R1", "rows on mid-run reset", int'(row_n), 5'b01111);
    chk(!key_valid && key_code == 0, "R1", "valid/code on mid-run reset", int'({key_valid, key_code}), 0);
    release_all();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule